// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block holds a programmed SDRAM mode word and, for each READ or WRITE burst, produces the column address of every beat. A load strobe writes the mode word, but only while all banks are idle. The stored word is decoded into these settings:

- burst length: 1, 2, 4, 8 or full page;
- burst order: sequential or interleaved;
- CAS latency;
- a write-single option, which makes every write one beat long while reads keep the programmed length.

Any reserved field combination raises an illegal-mode flag, and no burst starts while that flag is high.

A start strobe latches the start column and the direction. From the next cycle the block drives one column per cycle. Fixed-length bursts wrap inside the aligned block that the length selects. A full-page burst steps through the page, wraps modulo the page size, and runs until a terminate strobe. The control is a three-state machine:

- `ST_IDLE`, no burst;
- `ST_FIXED`, a fixed-length burst;
- `ST_PAGE`, a full-page burst.

The transitions are:

- *launch-fixed*: `ST_IDLE` to `ST_FIXED`.
- *launch-page*: `ST_IDLE` to `ST_PAGE`.
- *restart*: any busy state back into a fresh burst.
- *finish*: `ST_FIXED` to `ST_IDLE` after the last beat.
- *terminate*: `ST_FIXED` or `ST_PAGE` to `ST_IDLE` on a stop strobe.
- *hold*: a state stays where it is otherwise.

Top module: `sdram_burst_seq`

## Requirements
- R1: Mode bits 2:0 set the length. 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Codes 100, 101 and 110 raise `illegal_mode`.
- R2: Mode bit 3 selects the order: 0 is sequential and 1 is interleaved. Full page combined with interleaved raises `illegal_mode`.
- R3: Mode bits 6:4 give the CAS latency. 010 drives `cas_lat`=2 and 011 drives `cas_lat`=3. Any other code drives 0 and raises `illegal_mode`.
- R4: A nonzero value in mode bits 8:7 raises `illegal_mode`, and so does a nonzero value in bits 12:10. While `illegal_mode` is high, a start strobe is ignored.
- R5: A load with `banks_idle`=0 leaves the stored mode unchanged. It also raises `load_err` for exactly the following cycle.
- R6: For length L in sequential order, beat i has low bits (start+i) mod L. Here L is 2, 4 or 8, and the low bits are log2(L) wide. The column bits above them equal the start column.
- R7: In interleaved order, beat i has low bits start XOR i. The upper bits are held.
- R8: With mode bit 9 = 1, a write burst is one beat long and reads keep the programmed length. With bit 9 = 0, writes use the programmed length.
- R9: A full-page burst gives column (start+i) mod 2^COL_W and continues until terminated. `last_beat` never rises during it.
- R10: The first beat appears the cycle after the start strobe. `last_beat` is high only on the final beat of a fixed-length burst, and `burst_busy` falls the next cycle.
- R11: A start strobe during an active burst restarts the sequence from the new start column on the next cycle.
- R12: A terminate strobe ends an active burst after the current beat. A terminate strobe while idle has no effect.
- R13: After reset the stored mode is 0x020 (length 1, sequential, CAS 2). `burst_busy`, `last_beat`, `load_err` and `illegal_mode` are 0. `col_out` is 0 whenever no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Mode word load strobe |
| mode_val | input | 13 | Mode word to load |
| banks_idle | input | 1 | High when all banks are idle |
| burst_go | input | 1 | Burst start strobe |
| start_col | input | COL_W | Start column address |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | Burst terminate strobe |
| col_out | output | COL_W | Column address of the current beat |
| burst_busy | output | 1 | A burst beat is being driven |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (0 when reserved) |
| illegal_mode | output | 1 | Stored mode word uses a reserved setting |
| load_err | output | 1 | One-cycle pulse after a rejected load |

## Verification
The sequences are chosen in pairs so that each order can be told apart from the other. A start column of 0x4D gives different sequences under sequential and interleaved order, where a start of 0x4E would not, and 0x15 separates the two orders at length 8. A start column near the top of the page shows whether a fixed burst wraps inside its aligned block or crosses into the next one. A full-page burst starting at 0xFD shows whether the page wraps modulo 256. The same mode is run as a read and as a write, which shows that the write-single option acts on writes only. Restart, terminate (while idle, mid fixed burst and mid page burst), a rejected load and each class of reserved field are driven as directed cases.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int MODE_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bseq_state_e;

    typedef struct packed {
        logic [1:0] len_lg;     // log2 of fixed length
        logic       full_page;
        logic       interleave;
        logic       wr_single;
        logic [1:0] cas;
        logic       illegal;
    } bseq_mode_t;
endpackage

// File: rtl/bseq_mode_dec.sv
module bseq_mode_dec
    import bseq_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode_word,
    output bseq_mode_t    dec
);
    logic bl_bad;
    logic cas_bad;
    logic rsv_bad;

    always_comb begin
        dec       = '0;
        bl_bad    = 1'b0;
        unique case (mode_word[2:0])
            3'b000:  dec.len_lg = 2'd0;
            3'b001:  dec.len_lg = 2'd1;
            3'b010:  dec.len_lg = 2'd2;
            3'b011:  dec.len_lg = 2'd3;
            3'b111:  dec.full_page = 1'b1;
            default: bl_bad = 1'b1;
        endcase
        dec.interleave = mode_word[3];
        cas_bad = 1'b0;
        unique case (mode_word[6:4])
            3'b010:  dec.cas = 2'd2;
            3'b011:  dec.cas = 2'd3;
            default: cas_bad = 1'b1;
        endcase
        dec.wr_single = mode_word[9];
        rsv_bad = (mode_word[8:7] != 2'b00) || (mode_word[MW-1:10] != '0);
        dec.illegal = bl_bad || cas_bad || rsv_bad ||
                      (dec.full_page && dec.interleave);
    end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  logic [1:0]       len_lg,
    input  logic             full_page,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] int_low;

    always_comb begin
        mask    = ~({COL_W{1'b1}} << len_lg);
        seq_low = (base_col + beat) & mask;
        int_low = (base_col ^ beat) & mask;
        if (full_page) begin
            col = base_col + beat;
        end else begin
            col = (base_col & ~mask) | (interleave ? int_low : seq_low);
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import bseq_pkg::*;
#(
    parameter int               COL_W    = 8,
    parameter logic [MODE_W-1:0] MODE_RST = 13'h020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ld,
    input  logic [12:0]      mode_val,
    input  logic             banks_idle,
    input  logic             burst_go,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             burst_busy,
    output logic             last_beat,
    output logic [1:0]       cas_lat,
    output logic             illegal_mode,
    output logic             load_err
);
    logic [MODE_W-1:0] mode_q;
    bseq_mode_t        dec;
    bseq_state_e       state_q, state_d;
    logic [COL_W-1:0]  start_q, cnt_q, gen_col;
    logic [1:0]        lg_q;
    logic              inter_q;
    logic              go_ok, single_wr, page_go, at_last;
    logic [1:0]        eff_lg;

    bseq_mode_dec #(.MW(MODE_W)) u_dec (.mode_word(mode_q), .dec(dec));

    bseq_addr_gen #(.COL_W(COL_W)) u_gen (
        .base_col  (start_q),
        .beat      (cnt_q),
        .len_lg    (lg_q),
        .full_page (state_q == ST_PAGE),
        .interleave(inter_q),
        .col       (gen_col)
    );

    // mode word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RST;
            load_err <= 1'b0;
        end else begin
            load_err <= mode_ld && !banks_idle;
            if (mode_ld && banks_idle) mode_q <= mode_val;
        end
    end

    assign go_ok     = burst_go && !dec.illegal;
    assign single_wr = is_write && dec.wr_single;
    assign eff_lg    = single_wr ? 2'd0 : dec.len_lg;
    assign page_go   = dec.full_page && !single_wr;
    assign at_last   = (cnt_q == ~({COL_W{1'b1}} << lg_q));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_ok) state_d = page_go ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (go_ok)                     state_d = page_go ? ST_PAGE : ST_FIXED;
                else if (burst_stop || at_last) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (go_ok)           state_d = page_go ? ST_PAGE : ST_FIXED;
                else if (burst_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            cnt_q   <= '0;
            lg_q    <= '0;
            inter_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go_ok) begin
                start_q <= start_col;
                cnt_q   <= '0;
                lg_q    <= eff_lg;
                inter_q <= dec.interleave;
            end else if (state_q != ST_IDLE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        burst_busy   = (state_q != ST_IDLE);
        last_beat    = (state_q == ST_FIXED) && at_last;
        col_out      = burst_busy ? gen_col : '0;
        cas_lat      = dec.cas;
        illegal_mode = dec.illegal;
    end

    // R5
    load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld && !banks_idle) |=> $stable(mode_q));

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !burst_go && !burst_stop) |=> !burst_busy);

    // R9
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_beat);

    // R11
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_go && !illegal_mode) |=> (burst_busy && col_out == $past(start_col)));

    // R12
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_go) |=> !burst_busy);

    // R13
    idle_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_busy |-> (col_out == '0));

    // R4
    illegal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_busy && illegal_mode) |=> !burst_busy);
endmodule

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int NVEC       = 9;

    // {mode 13, start 8, write 1, length 4, cas 2, beats 8x8}
    localparam logic [91:0] VECS [NVEC] = '{
        {13'h021, 8'h35, 1'b0, 4'd2, 2'd2, 64'h3534_0000_0000_0000},
        {13'h022, 8'h4E, 1'b0, 4'd4, 2'd2, 64'h4E4F_4C4D_0000_0000},
        {13'h02A, 8'h4D, 1'b0, 4'd4, 2'd2, 64'h4D4C_4F4E_0000_0000},
        {13'h033, 8'h15, 1'b0, 4'd8, 2'd3, 64'h1516_1710_1112_1314},
        {13'h03B, 8'h15, 1'b0, 4'd8, 2'd3, 64'h1514_1716_1110_1312},
        {13'h020, 8'h77, 1'b0, 4'd1, 2'd2, 64'h7700_0000_0000_0000},
        {13'h222, 8'h4E, 1'b1, 4'd1, 2'd2, 64'h4E00_0000_0000_0000},
        {13'h222, 8'h4E, 1'b0, 4'd4, 2'd2, 64'h4E4F_4C4D_0000_0000},
        {13'h023, 8'hFE, 1'b1, 4'd8, 2'd2, 64'hFEFF_F8F9_FAFB_FCFD}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_ld = 1'b0;
    logic [12:0]      mode_val = '0;
    logic             banks_idle = 1'b1;
    logic             burst_go = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             is_write = 1'b0;
    logic             burst_stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             burst_busy, last_beat, illegal_mode, load_err;
    logic [1:0]       cas_lat;
    int               checks = 0;
    int               failures = 0;
    bit               done = 1'b0;

    sdram_burst_seq #(.COL_W(COL_W)) u_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_val(mode_val),
        .banks_idle(banks_idle), .burst_go(burst_go), .start_col(start_col),
        .is_write(is_write), .burst_stop(burst_stop), .col_out(col_out),
        .burst_busy(burst_busy), .last_beat(last_beat), .cas_lat(cas_lat),
        .illegal_mode(illegal_mode), .load_err(load_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_mode(input logic [12:0] m, input logic idle);
        @(negedge clk);
        mode_ld = 1'b1; mode_val = m; banks_idle = idle;
        @(negedge clk);
        mode_ld = 1'b0; banks_idle = 1'b1;
    endtask

    task automatic start_burst(input logic [COL_W-1:0] c, input logic wr);
        @(negedge clk);
        burst_go = 1'b1; start_col = c; is_write = wr;
        @(negedge clk);
        burst_go = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [12:0] bad_modes [5];
        bad_modes = '{13'h024, 13'h02F, 13'h040, 13'h0A2, 13'h422};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13", "busy", burst_busy, 0);
        check("R13", "last", last_beat, 0);
        check("R13", "col", col_out, 0);
        check("R13", "illegal", illegal_mode, 0);
        check("R13", "load_err", load_err, 0);
        check("R13", "cas", cas_lat, 2);

        // table walk: R1 R3 R6 R7 R8 R10
        for (int v = 0; v < NVEC; v++) begin
            logic [12:0] m;
            int          len;
            string       tag;
            m   = VECS[v][91:79];
            len = int'(VECS[v][69:66]);
            tag = m[9] ? "R8" : (m[3] ? "R7" : "R6");
            load_mode(m, 1'b1);
            check("R3", "cas", cas_lat, 32'(VECS[v][65:64]));
            start_burst(VECS[v][78:71], VECS[v][70]);
            for (int b = 0; b < len; b++) begin
                check(tag, "col", col_out, 32'(VECS[v][63-8*b -: 8]));
                check("R10", "last", last_beat, (b == len - 1) ? 1 : 0);
                if (b < len - 1) @(negedge clk);
            end
            @(negedge clk);
            check("R1", "busy after length", burst_busy, 0);
        end

        // R9 full page wrap, terminated
        load_mode(13'h027, 1'b1);
        check("R2", "page seq legal", illegal_mode, 0);
        start_burst(8'hFD, 1'b0);
        for (int b = 0; b < 5; b++) begin
            check("R9", "page col", col_out, 32'((8'hFD + b) & 8'hFF));
            check("R9", "page last", last_beat, 0);
            if (b < 4) @(negedge clk);
        end
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R12", "stop page busy", burst_busy, 0);
        check("R13", "idle col", col_out, 0);

        // R12 stop while idle
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R12", "idle stop", burst_busy, 0);

        // R12 stop mid fixed burst
        load_mode(13'h023, 1'b1);
        start_burst(8'h15, 1'b0);
        check("R12", "col0", col_out, 32'h15);
        @(negedge clk);
        check("R12", "col1", col_out, 32'h16);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R12", "stop fixed busy", burst_busy, 0);

        // R11 restart mid burst
        start_burst(8'h15, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R11", "pre-restart col", col_out, 32'h17);
        burst_go = 1'b1; start_col = 8'h40;
        @(negedge clk);
        burst_go = 1'b0;
        for (int b = 0; b < 8; b++) begin
            check("R11", "restart col", col_out, 32'(8'h40 + b));
            if (b < 7) @(negedge clk);
        end
        check("R11", "restart last", last_beat, 1);
        @(negedge clk);
        check("R11", "restart end", burst_busy, 0);

        // R5 rejected load
        load_mode(13'h033, 1'b0);
        check("R5", "load_err pulse", load_err, 1);
        check("R5", "mode kept", cas_lat, 2);
        @(negedge clk);
        check("R5", "load_err clears", load_err, 0);

        // R1 R2 R3 R4 illegal modes
        for (int k = 0; k < 5; k++) begin
            load_mode(bad_modes[k], 1'b1);
            check(k == 0 ? "R1" : (k == 1 ? "R2" : (k == 2 ? "R3" : "R4")),
                  "illegal", illegal_mode, 1);
        end
        check("R3", "reserved cas", cas_lat, 2);
        load_mode(13'h040, 1'b1);
        check("R3", "cas zero", cas_lat, 0);
        start_burst(8'h10, 1'b0);
        check("R4", "go ignored", burst_busy, 0);
        load_mode(13'h022, 1'b1);
        check("R4", "legal again", illegal_mode, 0);

        finish_run();
    end
endmodule